// File: doc/BRIEF.md
# RAM-Backed Programmable Delay Line

This block delays a data stream by a programmable number of enabled clock cycles, from 0 to 63. The samples are not moved through a flop chain. Each one is written once into a small memory array and stays there. A write address and a read address step through the array together, and the gap between them sets the delay. For long delays this costs one memory row per stage, not a full register per stage.

A delay setting of zero routes the input straight to the output through a combinational bypass. For any other setting, the output comes from a register that is loaded on each enabled edge. The delay setting is sampled every cycle. When it changes, the read address is moved to the new spacing and the history is treated as empty. The output then reads zero until enough new samples have arrived. When the shift enable is low, the stream freezes.

Top module: `dly_ram_line`

## Requirements
- R1: While reset is asserted and just after it, the output is zero for any nonzero delay setting; the applied delay is taken as 0, the write address starts at entry 63 and the read address at entry 0.
- R2: On every edge with `shift_en` high, both addresses advance by one and wrap from 63 to 0, so a stream longer than 64 samples keeps its delay.
- R3: With `dly_sel` = 0, `dout` equals `din` combinationally in the same cycle.
- R4: With `dly_sel` = d in 1..63, after an enabled edge `dout` holds the `din` value sampled at the enabled edge d−1 enabled edges before that one. The output is therefore d enabled cycles behind the input now being presented.
- R5: After every edge, the read address equals (write address − applied delay + 1) mod 64. A new `dly_sel` value re-spaces the read address on the edge where the change is first seen.
- R6: After reset or after a change of `dly_sel`, the output stays zero until d samples have been written under the new setting.
- R7: On an edge with `shift_en` low and an unchanged `dly_sel`, neither address moves and `dout` holds its value.
- R8: A change of `dly_sel` seen on an edge with `shift_en` low clears the output register to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Advances the line by one stage when high |
| dly_sel | input | DLY_W (6) | Delay in stages, 0 to 63 |
| din | input | DATA_W (8) | Sample entering the line |
| dout | output | DATA_W (8) | Delayed sample |

## Verification
The bench builds the block with its default 8-bit samples and 6-bit delay field, so the array has 64 rows. With 64 rows, the longest delay of 63 fills all but one row, and a few hundred cycles wrap both addresses many times. A queue model in the bench predicts every output. Directed runs at delays 0, 1 and 63 are mixed with random delay changes and random gaps in the enable, including changes made while the enable is low.

// File: rtl/dly_pkg.sv
// Package: shared control record for the RAM-backed delay line.
// Assumes nothing; holds only types.
package dly_pkg;

    // Per-cycle control passed from the address controller to the output stage.
    typedef struct packed {
        logic step;     // the line advances on this edge
        logic restart;  // the delay setting differs from the applied one
        logic fill_ok;  // enough samples exist for the requested delay
        logic fwd;      // read and write hit the same row (delay 1)
    } dly_ctl_t;

endpackage

// File: rtl/dly_ptr_ctrl.sv
// Module: address controller. Holds the write and read addresses, the applied
// delay and a saturating count of samples written since the last restart.
// Assumes the array has 2**DLY_W rows and a delay of at most 2**DLY_W - 1.
module dly_ptr_ctrl
    import dly_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [DLY_W-1:0] dly_sel,
    output logic [DLY_W-1:0] wr_addr,
    output logic [DLY_W-1:0] rd_addr,
    output dly_ctl_t         ctl
);
    localparam int DEPTH = 1 << DLY_W;
    localparam int CNT_W = DLY_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [DLY_W-1:0] wr_q, rd_q, dly_q, rd_use;
    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_next;
    logic             restart;

    // Detect a new delay setting and pick the read address for this cycle.
    always_comb begin
        restart  = (dly_sel != dly_q);
        rd_use   = restart ? DLY_W'(wr_q - dly_sel + 1'b1) : rd_q;
        cnt_base = restart ? '0 : cnt_q;
        if (shift_en && cnt_base != CNT_MAX)
            cnt_next = cnt_base + 1'b1;
        else
            cnt_next = cnt_base;
    end

    // Build the control record for the output stage.
    always_comb begin
        ctl.step    = shift_en;
        ctl.restart = restart;
        ctl.fwd     = (rd_use == wr_q);
        ctl.fill_ok = shift_en && (dly_sel != '0) && (cnt_next >= {1'b0, dly_sel});
    end

    // Advance the addresses, track the applied delay and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= DLY_W'(DEPTH - 1);
            rd_q  <= '0;
            dly_q <= '0;
            cnt_q <= '0;
        end else begin
            dly_q <= dly_sel;
            cnt_q <= cnt_next;
            wr_q  <= shift_en ? DLY_W'(wr_q + 1'b1) : wr_q;
            rd_q  <= shift_en ? DLY_W'(rd_use + 1'b1) : rd_use;
        end
    end

    assign wr_addr = wr_q;
    assign rd_addr = rd_use;

    // R2: an enabled edge moves the write address by exactly one, with wrap.
    a_r2_wr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> wr_q == DLY_W'($past(wr_q) + 1'b1));

    // R5: the read address keeps the spacing set by the applied delay.
    a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q == DLY_W'(wr_q - dly_q + 1'b1));

    // R7: with no step and no change, both addresses stay put.
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !restart) |=> ($stable(wr_q) && $stable(rd_q)));

endmodule

// File: rtl/dly_store.sv
// Module: sample array. Writes one row per enabled edge and has an
// asynchronous read port. Assumes the caller never reads a row it has not
// written since the last restart.
module dly_store #(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [DLY_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DLY_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << DLY_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming sample in the row under the write address.
    always_ff @(posedge clk) begin
        if (we)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/dly_out_stage.sv
// Module: output stage. Loads the delayed sample into a register, forwarding
// the live input when the delay is one, forcing zero during fill, and muxes
// in the bypass for a zero delay. Assumes the control record is the same cycle's.
module dly_out_stage
    import dly_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dly_ctl_t          ctl,
    input  logic              bypass,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] pick, out_q;

    // Choose between the stored row and the sample being written now.
    always_comb begin
        pick = ctl.fwd ? din : rd_data;
    end

    // Load, hold or clear the output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (ctl.step)
            out_q <= ctl.fill_ok ? pick : '0;
        else if (ctl.restart)
            out_q <= '0;
    end

    assign dout = bypass ? din : out_q;

    // R6: a step made before the line has filled leaves a zero output.
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.step && !ctl.fill_ok) |=> out_q == '0);

    // R7: without a step or a change the output register holds.
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.step && !ctl.restart) |=> $stable(out_q));

    // R8: a change seen while stalled clears the output register.
    a_r8_stall_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.step && ctl.restart) |=> out_q == '0);

endmodule

// File: rtl/dly_ram_line.sv
// Module: top of the RAM-backed programmable delay line. Ties the address
// controller, the sample array and the output stage together.
// Assumes the delay field selects 0 to 2**DLY_W - 1 stages.
module dly_ram_line
    import dly_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DLY_W-1:0]  dly_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DLY_W-1:0]  wr_addr, rd_addr;
    logic [DATA_W-1:0] rd_data;
    dly_ctl_t          ctl;

    dly_ptr_ctrl #(.DLY_W(DLY_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .dly_sel  (dly_sel),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .ctl      (ctl)
    );

    dly_store #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_store (
        .clk     (clk),
        .we      (ctl.step),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    dly_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .bypass  (dly_sel == '0),
        .din     (din),
        .rd_data (rd_data),
        .dout    (dout)
    );

endmodule

// File: tb/dly_ram_line_tb_top.sv
// Bench: queue model of the delay line, directed corners plus seeded random runs.
module dly_ram_line_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [5:0] sel = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;

    int errs = 0;
    int checks = 0;
    int m_sel = 0;
    int m_cnt = 0;
    int en_total = 0;
    logic [7:0] m_exp = '0;
    logic [7:0] hist[$];

    always #2.5 clk = ~clk;

    dly_ram_line #(.DATA_W(8), .DLY_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(en),
        .dly_sel(sel), .din(din), .dout(dout)
    );

    // Compare one value and log a failure line.
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: dout=%0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Print the summary and stop.
    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Drive one cycle, advance the model from the requirements and check.
    task automatic cyc(input bit e, input int s, input logic [7:0] d);
        bit chg;
        string tag;
        @(negedge clk);
        en = e; sel = 6'(s); din = d;
        #1;
        if (s == 0) chk("R3", dout, d);
        @(posedge clk);
        #1;
        chg = (s != m_sel);
        if (chg) begin
            m_sel = s;
            m_cnt = 0;
            hist.delete();
            m_exp = '0;
        end
        if (e) begin
            en_total++;
            hist.push_back(d);
            if (hist.size() > 64) void'(hist.pop_front());
            if (m_cnt < 64) m_cnt++;
            if (s != 0 && m_cnt >= s) m_exp = hist[hist.size() - s];
            else m_exp = '0;
        end
        if (s != 0) begin
            if (chg && !e)          tag = "R8";
            else if (!e)            tag = "R7";
            else if (m_cnt < s)     tag = "R6";
            else if (en_total > 64) tag = "R2 R5 R4";
            else                    tag = "R4";
            chk(tag, dout, m_exp);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        sel = 6'd7;
        en = 1'b1;
        repeat (3) @(posedge clk);
        #1 chk("R1", dout, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // Directed corners: bypass, single stage, longest delay.
        for (int i = 0; i < 20; i++) cyc(1'b1, 0, 8'($urandom));
        for (int i = 0; i < 80; i++) cyc(1'b1, 1, 8'($urandom));
        for (int i = 0; i < 200; i++) cyc(1'b1, 63, 8'($urandom));
        for (int i = 0; i < 5; i++) cyc(1'b0, 63, 8'($urandom));
        for (int i = 0; i < 10; i++) cyc(1'b1, 63, 8'($urandom));
        cyc(1'b0, 10, 8'($urandom));
        for (int i = 0; i < 30; i++) cyc(1'b1, 10, 8'($urandom));
        // Random delays with random gaps in the enable.
        for (int seg = 0; seg < 24; seg++) begin
            int s;
            int len;
            s = int'($urandom % 64);
            len = 40 + int'($urandom % 100);
            for (int i = 0; i < len; i++)
                cyc(($urandom % 4) != 0, s, 8'($urandom));
        end
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

endmodule